// File: doc/BRIEF.md
# Interrupt Control Unit for Custom-Opcode Instructions

This unit sits beside the execute stage of a 32-bit RISC-V style core. It decodes the interrupt-management instructions that live in the custom0 major opcode and executes them. It holds the interrupt state: four shadow q-registers, a 32-bit disable mask, a pending latch and a down-counting timer. The core presents each instruction word with an issue strobe, the rs1 operand and the instruction's PC. The unit answers one cycle later with an optional register write, an optional PC redirect, a stall request used while the core waits for an interrupt, and a sticky halt flag.

Interrupt entry is decided at an issue boundary. When a pending source is not disabled and no handler is running, the issued instruction is dropped and fetch is redirected to a fixed vector. The dropped instruction's PC is saved in q0 and the bits being serviced are saved in q1. Further entries are blocked until the handler returns with retirq. An illegal-instruction or bus-error report is turned into a pending interrupt when its source is enabled. When that source is disabled, the report stops the core permanently.

Top module: `irqc_unit`

## Requirements
- R1: An instruction is acted on only when bits [6:0] equal 0001011 and bits [31:25] are one of 0000000 (getq), 0000001 (setq), 0000010 (retirq), 0000011 (maskirq), 0000100 (waitirq) or 0000101 (timer). Any other word produces no register write and no redirect.
- R2: setq copies rs1 into the q-register selected by instruction bits [8:7]. getq writes the q-register selected by bits [16:15] to rd, and rd is instruction bits [11:7].
- R3: maskirq returns the previous mask in rd and loads rs1 as the new mask, where a 1 disables a source. After reset the mask is all ones.
- R4: A pending bit is set by a 0-to-1 transition of its request line. A line held high does not set it again after it has been cleared.
- R5: On an issue with no handler active and any pending bit not disabled, the instruction is dropped and fetch is redirected to IRQ_VECTOR. The instruction's PC goes to q0 and the serviced bits go to q1, and those bits are cleared. No other entry occurs until retirq.
- R6: retirq redirects fetch to the value in q0 and allows interrupt entry again.
- R7: waitirq writes the enabled pending bits to rd at once if any are set. Otherwise it raises stall and, once a bit becomes pending, writes them to rd and drops stall. The reported bits are cleared.
- R8: timer returns the counter's old value in rd and loads rs1. The counter decrements each cycle while nonzero, and its 1-to-0 step sets pending bit TIMER_SRC. A value of zero leaves it idle.
- R9: An illegal-instruction report sets pending bit ILL_SRC and a bus-error report sets pending bit BUS_SRC when that bit is enabled. If the bit is disabled, halt rises and stays high, and later issues produce no output.
- R10: A result aimed at rd index 0 is discarded, so no write strobe is given.
- R11: Register write and redirect outputs are one-cycle pulses that appear on the clock edge after the issue that caused them. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction in instr_i is issued this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of the rs1 operand |
| pc_i | input | 32 | PC of the issued instruction |
| irq_i | input | 32 | Interrupt request lines |
| fault_ill_i | input | 1 | Illegal-instruction report |
| fault_bus_i | input | 1 | Bus-error report |
| rd_we_o | output | 1 | Register write strobe |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 32 | Value to write |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| stall_o | output | 1 | Hold fetch while waiting for an interrupt |
| halt_o | output | 1 | Core halted by a masked fault |

## Verification
The q-register and mask paths are driven with random setq, getq and maskirq mixes, including rd index 0. This separates wrong index fields, lost writes and stale mask returns. Directed sequences cover several cases:
- an entry, a second request arriving inside the handler, and the return, which shows whether entry blocking and q0/q1 capture hold;
- a held-high request line followed by a low-high pulse while waiting, which separates edge latching from level latching;
- a timer expiry that ends a wait;
- an enabled fault that vectors and a disabled fault that halts, which tells trap from stop.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

    localparam logic [6:0] F7_GETQ  = 7'b0000000;
    localparam logic [6:0] F7_SETQ  = 7'b0000001;
    localparam logic [6:0] F7_RET   = 7'b0000010;
    localparam logic [6:0] F7_MASK  = 7'b0000011;
    localparam logic [6:0] F7_WAIT  = 7'b0000100;
    localparam logic [6:0] F7_TIMER = 7'b0000101;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GETQ,
        OP_SETQ,
        OP_RET,
        OP_MASK,
        OP_WAIT,
        OP_TIMER
    } irqc_op_e;

    typedef struct packed {
        irqc_op_e   op;
        logic [4:0] rd;
        logic [4:0] rs1f;
    } irqc_dec_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [31:0] instr_i,
    output irqc_dec_t   dec_o
);
    always_comb begin
        dec_o.rd   = instr_i[11:7];
        dec_o.rs1f = instr_i[19:15];
        dec_o.op   = OP_NONE;
        if (instr_i[6:0] == OPC_CUSTOM0) begin
            unique case (instr_i[31:25])
                F7_GETQ:  dec_o.op = OP_GETQ;
                F7_SETQ:  dec_o.op = OP_SETQ;
                F7_RET:   dec_o.op = OP_RET;
                F7_MASK:  dec_o.op = OP_MASK;
                F7_WAIT:  dec_o.op = OP_WAIT;
                F7_TIMER: dec_o.op = OP_TIMER;
                default:  dec_o.op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines_i;
        rise_o = lines_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
        else                    cnt_d = cnt_q;
        expire_o = !load_i && (cnt_q == W'(1));
        count_o  = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter int          W          = 32,
    parameter int          NQ         = 4,
    parameter logic [31:0] IRQ_VECTOR = 32'h0000_0010,
    parameter int          TIMER_SRC  = 0,
    parameter int          ILL_SRC    = 1,
    parameter int          BUS_SRC    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [31:0]  instr_i,
    input  logic [W-1:0] rs1_val_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] irq_i,
    input  logic         fault_ill_i,
    input  logic         fault_bus_i,
    output logic         rd_we_o,
    output logic [4:0]   rd_idx_o,
    output logic [W-1:0] rd_data_o,
    output logic         redirect_o,
    output logic [W-1:0] redirect_pc_o,
    output logic         stall_o,
    output logic         halt_o
);
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

    typedef struct packed {
        logic [NQ-1:0][W-1:0] q;
        logic [W-1:0]         mask;
        logic [W-1:0]         pend;
        logic                 active;
        logic                 waiting;
        logic [4:0]           wait_rd;
        logic                 halt;
        logic                 rd_we;
        logic [4:0]           rd_idx;
        logic [W-1:0]         rd_data;
        logic                 redir;
        logic [W-1:0]         redir_pc;
    } state_t;

    state_t       s_d, s_q;
    irqc_dec_t    dec;
    logic [W-1:0] rise, tmr_count, visible, clr, set;
    logic         tmr_load, tmr_expire;

    irqc_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    irqc_edge #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_i(irq_i), .rise_o(rise)
    );

    irqc_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(rs1_val_i),
        .count_o(tmr_count), .expire_o(tmr_expire)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rd_we  = 1'b0;
        s_d.rd_idx = dec.rd;
        s_d.rd_data = '0;
        s_d.redir  = 1'b0;
        s_d.redir_pc = '0;
        tmr_load   = 1'b0;
        visible    = s_q.pend & ~s_q.mask;
        clr        = '0;
        set        = rise;
        if (tmr_expire) set[TIMER_SRC] = 1'b1;
        if (fault_ill_i) begin
            if (s_q.mask[ILL_SRC]) s_d.halt = 1'b1;
            else                   set[ILL_SRC] = 1'b1;
        end
        if (fault_bus_i) begin
            if (s_q.mask[BUS_SRC]) s_d.halt = 1'b1;
            else                   set[BUS_SRC] = 1'b1;
        end

        if (!s_q.halt) begin
            if (s_q.waiting) begin
                if (visible != '0) begin
                    s_d.waiting = 1'b0;
                    s_d.rd_idx  = s_q.wait_rd;
                    s_d.rd_we   = (s_q.wait_rd != 5'd0);
                    s_d.rd_data = visible;
                    clr         = visible;
                end
            end else if (issue_i) begin
                if (!s_q.active && visible != '0) begin
                    s_d.q[0]     = pc_i;
                    s_d.q[1]     = visible;
                    clr          = visible;
                    s_d.active   = 1'b1;
                    s_d.redir    = 1'b1;
                    s_d.redir_pc = IRQ_VECTOR;
                end else begin
                    unique case (dec.op)
                        OP_GETQ: begin
                            s_d.rd_we   = (dec.rd != 5'd0);
                            s_d.rd_data = s_q.q[dec.rs1f[QW-1:0]];
                        end
                        OP_SETQ: s_d.q[dec.rd[QW-1:0]] = rs1_val_i;
                        OP_RET: begin
                            s_d.redir    = 1'b1;
                            s_d.redir_pc = s_q.q[0];
                            s_d.active   = 1'b0;
                        end
                        OP_MASK: begin
                            s_d.rd_we   = (dec.rd != 5'd0);
                            s_d.rd_data = s_q.mask;
                            s_d.mask    = rs1_val_i;
                        end
                        OP_WAIT: begin
                            if (visible != '0) begin
                                s_d.rd_we   = (dec.rd != 5'd0);
                                s_d.rd_data = visible;
                                clr         = visible;
                            end else begin
                                s_d.waiting = 1'b1;
                                s_d.wait_rd = dec.rd;
                            end
                        end
                        OP_TIMER: begin
                            s_d.rd_we   = (dec.rd != 5'd0);
                            s_d.rd_data = tmr_count;
                            tmr_load    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
        s_d.pend = (s_q.pend & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_we_o       = s_q.rd_we;
    assign rd_idx_o      = s_q.rd_idx;
    assign rd_data_o     = s_q.rd_data;
    assign redirect_o    = s_q.redir;
    assign redirect_pc_o = s_q.redir_pc;
    assign stall_o       = s_q.waiting;
    assign halt_o        = s_q.halt;
endmodule

// File: rtl/irqc_unit_chk.sv
module irqc_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_i,
    input logic       rd_we_o,
    input logic [4:0] rd_idx_o,
    input logic       redirect_o,
    input logic       stall_o,
    input logic       halt_o
);
    AST_RD_ZERO_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> rd_idx_o != 5'd0); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o); // R9
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (!rd_we_o && !redirect_o)); // R9
    AST_WAIT_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> !redirect_o); // R7
    AST_WAIT_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(issue_i)); // R7
    AST_REDIRECT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> $past(issue_i)); // R11
endmodule

bind irqc_unit irqc_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rd_we_o(rd_we_o),
    .rd_idx_o(rd_idx_o), .redirect_o(redirect_o), .stall_o(stall_o),
    .halt_o(halt_o)
);

// File: tb/irqc_unit_tb_top.sv
`timescale 1ns/1ps
module irqc_unit_tb_top;
    localparam logic [31:0] VEC = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0, rs1v = '0, pcv = '0, irq = '0;
    logic        f_ill = 1'b0, f_bus = 1'b0;
    logic        rd_we, redir, stall, halt;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data, redir_pc;
    int          n_chk = 0, n_err = 0, cyc = 0;
    logic [31:0] mq [4];
    logic [31:0] mmask;

    always #2 clk = ~clk;

    irqc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr),
        .rs1_val_i(rs1v), .pc_i(pcv), .irq_i(irq), .fault_ill_i(f_ill),
        .fault_bus_i(f_bus), .rd_we_o(rd_we), .rd_idx_o(rd_idx),
        .rd_data_o(rd_data), .redirect_o(redir), .redirect_pc_o(redir_pc),
        .stall_o(stall), .halt_o(halt)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs1f,
                                       input logic [4:0] rdf);
        return {f7, 5'd0, rs1f, 3'b000, rdf, 7'b0001011};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [31:0] ins, input logic [31:0] v, input logic [31:0] pc);
        @(negedge clk);
        instr = ins; rs1v = v; pcv = pc; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic wait_wb(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (rd_we) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {28'd0, rd_we, redir, stall, halt}, 32'd0);

        // R3 reset mask all ones, previous value returned
        do_op(mk(7'b0000011, 5'd1, 5'd5), 32'd0, 32'h40);
        chk("R3 we", {31'd0, rd_we}, 32'd1);
        chk("R3 old mask", rd_data, 32'hFFFF_FFFF);
        // R10 rd=0 discarded while mask still updates
        do_op(mk(7'b0000011, 5'd1, 5'd0), 32'h1234_5678, 32'h44);
        chk("R10 no write", {31'd0, rd_we}, 32'd0);
        do_op(mk(7'b0000011, 5'd1, 5'd6), 32'hFFFF_FFF0, 32'h48);
        chk("R3 returns prior", rd_data, 32'h1234_5678);
        chk("R11 rd index", {27'd0, rd_idx}, 32'd6);
        mmask = 32'hFFFF_FFF0;

        // R1 other opcode and unknown funct7 ignored
        do_op({7'b0000000, 5'd0, 5'd1, 3'b000, 5'd3, 7'b0110011}, 32'd9, 32'h4C);
        chk("R1 foreign opcode", {30'd0, rd_we, redir}, 32'd0);
        do_op(mk(7'b0000110, 5'd1, 5'd3), 32'd9, 32'h50);
        chk("R1 unknown funct7", {30'd0, rd_we, redir}, 32'd0);

        // R2 setq / getq field positions
        do_op(mk(7'b0000001, 5'd4, 5'd2), 32'hCAFE_0002, 32'h54);
        chk("R2 setq silent", {31'd0, rd_we}, 32'd0);
        do_op(mk(7'b0000000, 5'd2, 5'd7), 32'd0, 32'h58);
        chk("R2 getq q2", rd_data, 32'hCAFE_0002);

        // R4/R5 entry on rising edge
        @(negedge clk); irq[3] = 1'b1;
        do_op(mk(7'b0000000, 5'd2, 5'd7), 32'd0, 32'h100);
        chk("R5 redirect", {31'd0, redir}, 32'd1);
        chk("R5 vector", redir_pc, VEC);
        chk("R5 dropped instr", {31'd0, rd_we}, 32'd0);
        do_op(mk(7'b0000000, 5'd0, 5'd8), 32'd0, VEC);
        chk("R5 q0 return pc", rd_data, 32'h100);
        do_op(mk(7'b0000000, 5'd1, 5'd9), 32'd0, VEC + 4);
        chk("R5 q1 pending", rd_data, 32'h8);
        // second request inside handler must not vector
        @(negedge clk); irq[2] = 1'b1;
        do_op(mk(7'b0000000, 5'd0, 5'd10), 32'd0, VEC + 8);
        chk("R5 blocked in handler", {31'd0, redir}, 32'd0);
        chk("R5 handler instr runs", rd_data, 32'h100);
        // R7 immediate waitirq inside handler
        @(negedge clk); irq[1] = 1'b1;
        do_op(mk(7'b0000100, 5'd0, 5'd11), 32'd0, VEC + 12);
        chk("R7 immediate bits", rd_data, 32'h6);
        chk("R7 no stall", {31'd0, stall}, 32'd0);
        // R6 return
        do_op(mk(7'b0000010, 5'd0, 5'd0), 32'd0, VEC + 16);
        chk("R6 redirect", {31'd0, redir}, 32'd1);
        chk("R6 target q0", redir_pc, 32'h100);

        // R7 stall path, R4 held level does not relatch
        do_op(mk(7'b0000100, 5'd0, 5'd11), 32'd0, 32'h100);
        chk("R4 held level no entry", {31'd0, redir}, 32'd0);
        chk("R7 stall raised", {31'd0, stall}, 32'd1);
        irq[3] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 falling edge ignored", {31'd0, stall}, 32'd1);
        irq[3] = 1'b1;
        wait_wb(8);
        chk("R7 wake write", {31'd0, rd_we}, 32'd1);
        chk("R7 wake bits", rd_data, 32'h8);
        chk("R7 wake rd", {27'd0, rd_idx}, 32'd11);
        chk("R7 stall dropped", {31'd0, stall}, 32'd0);

        // R8 timer
        do_op(mk(7'b0000101, 5'd2, 5'd12), 32'd5, 32'h104);
        chk("R8 old idle count", rd_data, 32'd0);
        do_op(mk(7'b0000101, 5'd2, 5'd13), 32'd3, 32'h108);
        chk("R8 old count after one tick", rd_data, 32'd4);
        do_op(mk(7'b0000100, 5'd0, 5'd14), 32'd0, 32'h10C);
        chk("R8 waiting on timer", {31'd0, stall}, 32'd1);
        wait_wb(10);
        chk("R8 expiry bit", rd_data, 32'h1);
        do_op(mk(7'b0000101, 5'd0, 5'd15), 32'd0, 32'h110);
        chk("R8 stays zero", rd_data, 32'd0);

        // R2/R3/R10 random mix against bench model
        for (int k = 0; k < 4; k++) begin
            mq[k] = $urandom;
            do_op(mk(7'b0000001, 5'd0, 5'(k)), mq[k], 32'h200);
        end
        for (int n = 0; n < 150; n++) begin
            int unsigned kind;
            logic [4:0]  rdr;
            logic [1:0]  sel;
            logic [31:0] val;
            kind = $urandom % 3;
            rdr = 5'($urandom);
            sel = 2'($urandom);
            val = $urandom;
            if (kind == 0) begin
                do_op(mk(7'b0000001, 5'd0, {3'($urandom), sel}), val, 32'h300);
                mq[sel] = val;
                chk("R2 random setq quiet", {31'd0, rd_we}, 32'd0);
            end else if (kind == 1) begin
                do_op(mk(7'b0000000, {3'($urandom), sel}, rdr), 32'd0, 32'h300);
                chk("R10 random getq we", {31'd0, rd_we}, {31'd0, rdr != 5'd0});
                if (rdr != 5'd0) chk("R2 random getq", rd_data, mq[sel]);
            end else begin
                do_op(mk(7'b0000011, 5'd0, rdr), val, 32'h300);
                chk("R10 random mask we", {31'd0, rd_we}, {31'd0, rdr != 5'd0});
                if (rdr != 5'd0) chk("R3 random mask", rd_data, mmask);
                mmask = val;
            end
        end
        do_op(mk(7'b0000011, 5'd0, 5'd4), 32'hFFFF_FFF0, 32'h400);
        chk("R3 final mask", rd_data, mmask);

        // R9 enabled bus fault vectors
        @(negedge clk); f_bus = 1'b1;
        @(negedge clk); f_bus = 1'b0;
        do_op(mk(7'b0000000, 5'd0, 5'd3), 32'd0, 32'h500);
        chk("R9 fault vectors", {31'd0, redir}, 32'd1);
        do_op(mk(7'b0000000, 5'd1, 5'd3), 32'd0, VEC);
        chk("R9 bus source bit", rd_data, 32'h4);
        do_op(mk(7'b0000010, 5'd0, 5'd0), 32'd0, VEC + 4);
        chk("R9 no halt when enabled", {31'd0, halt}, 32'd0);
        // R9 disabled illegal fault halts
        do_op(mk(7'b0000011, 5'd0, 5'd4), 32'hFFFF_FFFF, 32'h500);
        @(negedge clk); f_ill = 1'b1;
        @(negedge clk); f_ill = 1'b0;
        chk("R9 halt raised", {31'd0, halt}, 32'd1);
        do_op(mk(7'b0000000, 5'd0, 5'd15), 32'd0, 32'h504);
        chk("R9 halted ignores issue", {30'd0, rd_we, redir}, 32'd0);
        chk("R9 halt sticky", {31'd0, halt}, 32'd1);

        finish_run();
    end
endmodule